// File: doc/BRIEF.md
# USB IN Endpoint Response Controller

This block holds the control state of one USB device IN endpoint and picks the answer to every IN token the host sends. The answer is one of silence, NAK, STALL, a data packet with the current DATA0/DATA1 PID, or a zero-length data packet. The choice depends on the endpoint enable, the stall request, the transfer type (bulk/interrupt or isochronous), how many packets software has queued, and whether a start-of-frame token has been seen.

The token decoder sends single-cycle events for IN, SOF, a received ACK and a bus reset. Software actions arrive as single-cycle pulses: load a packet, write the stall request, clear the toggle, flush, and acknowledge a flag. Transfer settings arrive as levels. The block counts queued packets itself, up to `SLOTS`. The response to an IN token appears one clock after the token. An interrupt pulse marks a sent stall, a retired packet, or an isochronous underrun.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: With `ep_en` low, an IN token produces `resp_vld` with code SILENT (0) one cycle later. It changes no flag and no packet count. This holds even when a stall is requested or packets are queued.
- R2: With the endpoint enabled and the stall request set (last `stall_wr` carried `stall_val`=1), an IN token is answered with STALL (code 2) and sets `stl_flag`. A `stl_ack` pulse clears `stl_flag`. A stall request takes precedence over any data.
- R3: In bulk mode (`iso_en`=0), an IN token is answered with DATA (code 3) when at least one packet is queued, and with NAK (code 1) otherwise. `resp_pid` gives the toggle: 0 means DATA0 and 1 means DATA1.
- R4: With `force_tgl`=0, a bulk packet stays queued and the toggle stays the same until an ACK arrives after that packet's DATA response. That ACK flips the toggle and retires the packet. Without an ACK, the next IN resends the same PID. An ACK that does not follow a DATA response has no effect.
- R5: With `force_tgl`=1, every bulk DATA response flips the toggle and retires its packet, whether or not an ACK arrives.
- R6: A `tgl_clr` pulse sets the toggle to DATA0. This takes precedence over a flip in the same cycle.
- R7: In isochronous mode, no NAK is ever sent, and every DATA response uses DATA0 and retires its packet at once. An IN token that finds no queued packet gets a zero-length packet (code 4) and sets `urun_flag`. A `urun_ack` pulse clears `urun_flag`.
- R8: In isochronous mode with `sof_hold`=1, a queued packet is sent only after a SOF token has been seen while the packet was queued. An earlier IN gets a zero-length packet and raises no underrun.
- R9: `fifo_ne` is 1 while one or more packets are queued. `pkt_rdy` is 1 only when all `SLOTS` slots are full. A `pkt_load` pulse while all slots are full is ignored.
- R10: A `flush` pulse empties every queued packet and drops any pending SOF release or ACK wait.
- R11: A `bus_rst` pulse clears the toggle, the stall request, the queued packets and all flags. It also suppresses any response or interrupt for that cycle.
- R12: `irq` pulses for one cycle, one cycle after a STALL is sent, a packet is retired, or an underrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | Bus reset detected (pulse) |
| tok_in | input | 1 | IN token for this endpoint (pulse) |
| tok_sof | input | 1 | SOF token (pulse) |
| ack_rx | input | 1 | ACK handshake received from host (pulse) |
| ep_en | input | 1 | Endpoint enable |
| iso_en | input | 1 | Isochronous transfer type |
| force_tgl | input | 1 | Flip toggle on every send without waiting for ACK |
| sof_hold | input | 1 | Isochronous packets wait for a SOF |
| pkt_load | input | 1 | Software marks one more packet ready (pulse) |
| stall_wr | input | 1 | Write strobe for the stall request |
| stall_val | input | 1 | Value written to the stall request |
| tgl_clr | input | 1 | Reset the toggle to DATA0 (pulse) |
| flush | input | 1 | Discard queued packets (pulse) |
| stl_ack | input | 1 | Clear the sent-stall flag (pulse) |
| urun_ack | input | 1 | Clear the underrun flag (pulse) |
| resp_vld | output | 1 | A response is issued this cycle |
| resp_code | output | 3 | 0 silent, 1 NAK, 2 STALL, 3 DATA, 4 zero-length |
| resp_pid | output | 1 | Data PID for DATA responses, 0=DATA0 and 1=DATA1 |
| pkt_rdy | output | 1 | All packet slots are full |
| fifo_ne | output | 1 | At least one packet is queued |
| urun_flag | output | 1 | Isochronous underrun occurred |
| stl_flag | output | 1 | A STALL has been sent |
| irq | output | 1 | Event pulse |

## Verification
The directed part walks through these cases:
- Bulk traffic with ACKs, without ACKs, and with a stray ACK. Together these separate toggle advance on ACK from toggle advance on send.
- The same traffic with force-toggle set, to show that retirement moves to send time.
- Isochronous requests with an empty queue, with a ready packet, and with a held packet before and after a SOF. These separate underrun from a held zero-length reply.
- Stall, disable, flush and bus reset applied on top of queued packets. These expose the priority order.

After that, random mixes of tokens, ACKs, software pulses and mode changes are compared every cycle against a reference model in the bench. This catches interactions such as loads into a full queue, or a toggle clear landing on the same cycle as an ACK.

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
  parameter int SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       tok_in,
  input  logic       tok_sof,
  input  logic       ack_rx,
  input  logic       ep_en,
  input  logic       iso_en,
  input  logic       force_tgl,
  input  logic       sof_hold,
  input  logic       pkt_load,
  input  logic       stall_wr,
  input  logic       stall_val,
  input  logic       tgl_clr,
  input  logic       flush,
  input  logic       stl_ack,
  input  logic       urun_ack,
  output logic       resp_vld,
  output logic [2:0] resp_code,
  output logic       resp_pid,
  output logic       pkt_rdy,
  output logic       fifo_ne,
  output logic       urun_flag,
  output logic       stl_flag,
  output logic       irq
);
  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [2:0] C_SIL = 3'd0, C_NAK = 3'd1, C_STL = 3'd2, C_DAT = 3'd3, C_ZLP = 3'd4;
  localparam logic [CW-1:0] FULL = CW'(SLOTS);

  logic [CW-1:0] cnt;
  logic tgl, stall, await_ack, armed;
  logic [2:0] code;

  wire has_pkt = cnt != '0;

  always_comb begin
    if (!ep_en)      code = C_SIL;
    else if (stall)  code = C_STL;
    else if (iso_en) code = (has_pkt && (!sof_hold || armed)) ? C_DAT : C_ZLP;
    else             code = has_pkt ? C_DAT : C_NAK;
  end

  wire sent     = tok_in && code == C_DAT;
  wire iso_snd  = sent && iso_en;
  wire frc_snd  = sent && !iso_en && force_tgl;
  wire ack_hit  = ack_rx && await_ack && !tok_in;
  wire retire   = iso_snd || frc_snd || ack_hit;
  wire flip     = frc_snd || ack_hit;
  wire stl_evt  = tok_in && code == C_STL;
  wire urun_evt = tok_in && code == C_ZLP && !has_pkt;
  wire load_ok  = pkt_load && cnt != FULL;

  assign pkt_rdy = cnt == FULL;
  assign fifo_ne = has_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; tgl <= 1'b0; stall <= 1'b0; await_ack <= 1'b0; armed <= 1'b0;
      stl_flag <= 1'b0; urun_flag <= 1'b0;
      resp_vld <= 1'b0; resp_code <= C_SIL; resp_pid <= 1'b0; irq <= 1'b0;
    end else if (bus_rst) begin
      cnt <= '0; tgl <= 1'b0; stall <= 1'b0; await_ack <= 1'b0; armed <= 1'b0;
      stl_flag <= 1'b0; urun_flag <= 1'b0;
      resp_vld <= 1'b0; resp_code <= C_SIL; resp_pid <= 1'b0; irq <= 1'b0;
    end else begin
      resp_vld  <= tok_in;
      resp_code <= tok_in ? code : C_SIL;
      resp_pid  <= sent && !iso_en && tgl;
      irq       <= stl_evt || urun_evt || retire;

      if (stall_wr) stall <= stall_val;

      if (stl_evt)       stl_flag <= 1'b1;
      else if (stl_ack)  stl_flag <= 1'b0;
      if (urun_evt)      urun_flag <= 1'b1;
      else if (urun_ack) urun_flag <= 1'b0;

      if (tgl_clr)   tgl <= 1'b0;
      else if (flip) tgl <= ~tgl;

      if (flush) begin
        cnt <= '0; await_ack <= 1'b0; armed <= 1'b0;
      end else begin
        cnt <= cnt + CW'(load_ok) - CW'(retire);
        if (tok_in)      await_ack <= sent && !iso_en && !force_tgl;
        else if (ack_rx) await_ack <= 1'b0;
        if (tok_sof && has_pkt) armed <= 1'b1;
        else if (iso_snd)       armed <= 1'b0;
      end
    end
  end
endmodule

module usb_in_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       tok_in,
  input logic       ep_en,
  input logic       iso_en,
  input logic       resp_vld,
  input logic [2:0] resp_code,
  input logic       resp_pid,
  input logic       pkt_rdy,
  input logic       fifo_ne,
  input logic       urun_flag,
  input logic       stl_flag,
  input logic       irq
);
  assert_silent_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in && !ep_en && !bus_rst |=> resp_vld && resp_code == 3'd0);
  assert_stall_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld && resp_code == 3'd2 |-> stl_flag);
  assert_nak_only_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld && resp_code == 3'd1 |-> !$past(fifo_ne));
  assert_iso_data0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld && resp_code == 3'd3 && $past(iso_en) |-> !resp_pid);
  assert_urun_on_zlp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun_flag) |-> resp_vld && resp_code == 3'd4);
  assert_rdy_implies_ne_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy |-> fifo_ne);
  assert_bus_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !fifo_ne && !stl_flag && !urun_flag && !resp_vld && !irq);
  assert_stall_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld && resp_code == 3'd2 |-> irq);
endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tok_in(tok_in), .ep_en(ep_en),
  .iso_en(iso_en), .resp_vld(resp_vld), .resp_code(resp_code), .resp_pid(resp_pid),
  .pkt_rdy(pkt_rdy), .fifo_ne(fifo_ne), .urun_flag(urun_flag), .stl_flag(stl_flag),
  .irq(irq)
);

// File: tb/test_usb_in_ep_ctrl.sv
`timescale 1ns/1ps
module test_usb_in_ep_ctrl;
  localparam int SLOTS = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_rst = 0, tok_in = 0, tok_sof = 0, ack_rx = 0, ep_en = 0, iso_en = 0;
  logic force_tgl = 0, sof_hold = 0, pkt_load = 0, stall_wr = 0, stall_val = 0;
  logic tgl_clr = 0, flush = 0, stl_ack = 0, urun_ack = 0;
  logic resp_vld, resp_pid, pkt_rdy, fifo_ne, urun_flag, stl_flag, irq;
  logic [2:0] resp_code;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_in_ep_ctrl #(.SLOTS(SLOTS)) i_usb_in_ep_ctrl (.*);

  int m_cnt; bit m_tgl, m_stall, m_await, m_armed, m_stl, m_urun;
  bit e_vld, e_pid, e_irq; int e_code;

  function automatic int pick_code();
    bit has = m_cnt != 0;
    if (!ep_en) return 0;
    if (m_stall) return 2;
    if (iso_en) return (has && (!sof_hold || m_armed)) ? 3 : 4;
    return has ? 3 : 1;
  endfunction

  task automatic model_step();
    int c = pick_code();
    bit has = m_cnt != 0;
    bit sent = tok_in && c == 3;
    bit isnd = sent && iso_en;
    bit fsnd = sent && !iso_en && force_tgl;
    bit ackh = ack_rx && m_await && !tok_in;
    bit ret = isnd || fsnd || ackh;
    bit stle = tok_in && c == 2;
    bit ure = tok_in && c == 4 && !has;
    if (bus_rst) begin
      m_cnt = 0; m_tgl = 0; m_stall = 0; m_await = 0; m_armed = 0; m_stl = 0; m_urun = 0;
      e_vld = 0; e_code = 0; e_pid = 0; e_irq = 0;
      return;
    end
    e_vld = tok_in; e_code = tok_in ? c : 0; e_pid = sent && !iso_en && m_tgl;
    e_irq = stle || ure || ret;
    if (stall_wr) m_stall = stall_val;
    if (stle) m_stl = 1; else if (stl_ack) m_stl = 0;
    if (ure) m_urun = 1; else if (urun_ack) m_urun = 0;
    if (tgl_clr) m_tgl = 0; else if (fsnd || ackh) m_tgl = !m_tgl;
    if (flush) begin
      m_cnt = 0; m_await = 0; m_armed = 0;
    end else begin
      m_cnt = m_cnt + ((pkt_load && m_cnt != SLOTS) ? 1 : 0) - (ret ? 1 : 0);
      if (tok_in) m_await = sent && !iso_en && !force_tgl;
      else if (ack_rx) m_await = 0;
      if (tok_sof && has) m_armed = 1;
      else if (isnd) m_armed = 0;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3 resp_vld", resp_vld, e_vld);
    chk("R3 resp_code", resp_code, e_code);
    chk("R4 resp_pid", resp_pid, e_pid);
    chk("R9 pkt_rdy", pkt_rdy, m_cnt == SLOTS);
    chk("R9 fifo_ne", fifo_ne, m_cnt != 0);
    chk("R7 urun_flag", urun_flag, m_urun);
    chk("R2 stl_flag", stl_flag, m_stl);
    chk("R12 irq", irq, e_irq);
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
    bus_rst = 0; tok_in = 0; tok_sof = 0; ack_rx = 0; pkt_load = 0; stall_wr = 0;
    tgl_clr = 0; flush = 0; stl_ack = 0; urun_ack = 0;
  endtask

  task automatic in_tok(); tok_in = 1; tick(); endtask
  task automatic ack(); ack_rx = 1; tick(); endtask
  task automatic load(); pkt_load = 1; tick(); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    m_cnt = 0; m_tgl = 0; m_stall = 0; m_await = 0; m_armed = 0; m_stl = 0; m_urun = 0;
    e_vld = 0; e_code = 0; e_pid = 0; e_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare();                                   // reset state, R11
    ep_en = 1;

    in_tok(); chk("R3 empty bulk NAK", resp_code, 1);
    load(); chk("R9 one queued ne", fifo_ne, 1); chk("R9 one queued rdy", pkt_rdy, 0);
    load(); chk("R9 full rdy", pkt_rdy, 1);
    load(); chk("R9 load when full", pkt_rdy, 1);
    in_tok(); chk("R3 data", resp_code, 3); chk("R4 first pid", resp_pid, 0);
    in_tok(); chk("R4 resend same pid", resp_pid, 0);
    ack(); chk("R4 ack retires", pkt_rdy, 0); chk("R12 retire irq", irq, 1);
    ack(); chk("R4 stray ack no effect", fifo_ne, 1);
    in_tok(); chk("R4 pid after ack", resp_pid, 1);
    ack();
    in_tok(); chk("R9 third load was ignored", resp_code, 1);

    load(); in_tok(); ack();                       // toggle back to 1
    tgl_clr = 1; load();
    in_tok(); chk("R6 clear toggle gives DATA0", resp_pid, 0);
    ack();

    force_tgl = 1; load(); load();
    in_tok(); chk("R5 forced pid a", resp_pid, 1);
    in_tok(); chk("R5 forced pid b", resp_pid, 0);
    chk("R5 retired without ack", fifo_ne, 0);
    force_tgl = 0;

    stall_val = 1; stall_wr = 1; load();
    in_tok(); chk("R2 stall", resp_code, 2); chk("R2 flag", stl_flag, 1); chk("R12 stall irq", irq, 1);
    stl_ack = 1; tick(); chk("R2 flag cleared", stl_flag, 0);

    ep_en = 0;
    in_tok(); chk("R1 silent", resp_code, 0); chk("R1 no stall flag", stl_flag, 0);
    chk("R1 packet kept", fifo_ne, 1);
    ep_en = 1; stall_val = 0; stall_wr = 1; tick();

    flush = 1; tick(); chk("R10 flush empties", fifo_ne, 0);
    in_tok(); chk("R10 NAK after flush", resp_code, 1);

    iso_en = 1;
    in_tok(); chk("R7 zlp on empty", resp_code, 4); chk("R7 underrun", urun_flag, 1);
    urun_ack = 1; tick(); chk("R7 underrun cleared", urun_flag, 0);
    load(); in_tok(); chk("R7 iso data", resp_code, 3); chk("R7 iso DATA0", resp_pid, 0);
    chk("R7 retired at send", fifo_ne, 0);

    sof_hold = 1; load();
    in_tok(); chk("R8 held zlp", resp_code, 4); chk("R8 no underrun", urun_flag, 0);
    chk("R8 packet kept", fifo_ne, 1);
    tok_sof = 1; tick();
    in_tok(); chk("R8 sent after SOF", resp_code, 3);
    sof_hold = 0; iso_en = 0;

    load(); stall_val = 1; stall_wr = 1; tick(); in_tok();
    bus_rst = 1; tick();
    chk("R11 queue cleared", fifo_ne, 0); chk("R11 stall flag cleared", stl_flag, 0);
    in_tok(); chk("R11 stall request cleared", resp_code, 1);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 16;
      if (i % 250 == 0) begin
        iso_en = $urandom % 3 == 0; force_tgl = $urandom % 3 == 0;
        sof_hold = $urandom % 2; ep_en = $urandom % 8 != 0;
      end
      tok_in = r < 4; tok_sof = r == 4; ack_rx = r == 5 || r == 6;
      pkt_load = r >= 7 && r <= 9;
      flush = $urandom % 64 == 0; bus_rst = $urandom % 300 == 0;
      tgl_clr = $urandom % 32 == 0; stall_wr = $urandom % 40 == 0; stall_val = $urandom % 3 == 0;
      stl_ack = $urandom % 8 == 0; urun_ack = $urandom % 8 == 0;
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule